// File: doc/BRIEF.md
# Call Progress Cadence Sequencer

This block plays the standard call-progress cadences by driving the 4-bit frequency code and the active-low enable of an external tone generator. The generator latches the code when its enable falls. A 4-bit pattern selector picks one of nine cadences. A one-cycle `start` pulse begins the cadence and a `stop` level ends it. While a cadence runs, the block steps through a fixed list of segments. Each segment holds a code, a tone-on or silent flag, a length in milliseconds and a rule for what follows: the next segment, a loop back to the first, a return to idle, or holding forever.

A prescaler divides the system clock by `MS_DIV`, which defaults to 3580 for a 3.579545 MHz clock, to make a millisecond tick. The prescaler and the millisecond counter restart at the first clock of every segment, so a segment always lasts exactly its nominal length in clocks. `busy` is high while a cadence is playing. The block uses nominal durations only and generates no tones itself.

Top module: `cadenceSeq`

## Requirements
- R1: After reset, and whenever no cadence is playing, `enN` is 1, `busy` is 0 and `codeOut` is 0.
- R2: Each segment lasts exactly its length in ms multiplied by `MS_DIV` clocks. The segment starts on the first clock after the `start` edge or after the previous segment ends.
- R3: On the first clock of a tone segment, `codeOut` shows the segment's code while `enN` stays 1. `enN` is 0 on every later clock of that segment and 1 throughout a silent segment. Two adjacent tone segments with different codes are therefore always separated by at least one clock with `enN` high.
- R4: Pattern 0 (dial) plays code 4'b0000 (350+440 Hz) steadily until stopped.
- R5: Pattern 1 (reorder) repeats code 4'b0110 (480+620 Hz) on for 250 ms, then silence for 250 ms. Pattern 2 (busy) does the same with 500 ms on and 500 ms off.
- R6: Pattern 3 (ring) repeats code 4'b0011 (440+480 Hz) on for 2000 ms, then silence for 4000 ms.
- R7: Pattern 4 (recall dial) plays three bursts of code 4'b0000, each 100 ms on and 100 ms off, and then holds code 4'b0000 steadily.
- R8: Pattern 5 (special ring) repeats code 4'b0011 for 1000 ms, then code 4'b0010 (440 Hz) for 200 ms, then 3000 ms of silence.
- R9: Pattern 6 (intercept) alternates code 4'b0010 (440 Hz) for 250 ms with code 4'b1000 (620 Hz) for 250 ms, with no silent segment between them.
- R10: Pattern 7 (call waiting) plays one 200 ms burst of code 4'b0010. Pattern 8 (confirmation) plays three 100 ms on / 100 ms off bursts of code 4'b0000. In both cases `busy` falls on the clock after the final segment ends.
- R11: While `stop` is 1, `enN` is 1 in that same cycle. The block is idle after the next clock edge. `stop` takes priority over `start`.
- R12: A `start` while a cadence is playing restarts the newly selected pattern from its first segment.
- R13: A `start` with `patSel` greater than 8 is ignored and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to play the pattern on patSel |
| stop | input | 1 | Request to silence and return to idle |
| patSel | input | 4 | Cadence selector, valid values 0 to 8 |
| codeOut | output | 4 | Frequency code for the tone generator |
| enN | output | 1 | Active-low tone enable; the generator latches codeOut on its falling edge |
| busy | output | 1 | High while a cadence is playing |

## Verification
Every pattern is played with a short tick divider and compared cycle by cycle against a segment list written out in the bench. Repeating cadences are followed through at least two loops, so an error in the loop-back rule cannot hide behind a correct first pass. The one-shot patterns and recall dial separate stop, loop and hold endings. Intercept exercises the gap between codes. Stop in the middle of a tone, stop together with start, restart to a different pattern while playing, and a start with every invalid selector each expose a separate priority path.

// File: rtl/cadence_pkg.sv
package cadence_pkg;

  localparam int DUR_W   = 13;
  localparam int IDX_W   = 3;
  localparam int NUM_PAT = 9;

  localparam logic [3:0] TONE_350_440 = 4'b0000;
  localparam logic [3:0] TONE_440_480 = 4'b0011;
  localparam logic [3:0] TONE_480_620 = 4'b0110;
  localparam logic [3:0] TONE_440     = 4'b0010;
  localparam logic [3:0] TONE_620     = 4'b1000;

  typedef enum logic [1:0] {NX_NEXT, NX_LOOP, NX_STOP, NX_HOLD} nextKind_e;

  typedef struct packed {
    logic [3:0]       code;
    logic             tone;
    logic [DUR_W-1:0] durMs;
    nextKind_e        nxt;
  } seg_t;

  typedef struct packed {
    logic restart;
    logic run;
  } dpCtl_t;

  function automatic seg_t mkSeg(logic [3:0] code, logic tone, int dur, nextKind_e nxt);
    seg_t s;
    s.code  = code;
    s.tone  = tone;
    s.durMs = DUR_W'(dur);
    s.nxt   = nxt;
    return s;
  endfunction

  function automatic seg_t segFetch(logic [3:0] pat, logic [IDX_W-1:0] idx);
    case (pat)
      4'd0: return mkSeg(TONE_350_440, 1'b1, 0, NX_HOLD);
      4'd1: return idx[0] ? mkSeg(TONE_480_620, 1'b0, 250, NX_LOOP)
                          : mkSeg(TONE_480_620, 1'b1, 250, NX_NEXT);
      4'd2: return idx[0] ? mkSeg(TONE_480_620, 1'b0, 500, NX_LOOP)
                          : mkSeg(TONE_480_620, 1'b1, 500, NX_NEXT);
      4'd3: return idx[0] ? mkSeg(TONE_440_480, 1'b0, 4000, NX_LOOP)
                          : mkSeg(TONE_440_480, 1'b1, 2000, NX_NEXT);
      4'd4: return (idx == 3'd6) ? mkSeg(TONE_350_440, 1'b1, 0, NX_HOLD)
                                 : mkSeg(TONE_350_440, !idx[0], 100, NX_NEXT);
      4'd5: begin
        if (idx == 3'd0) return mkSeg(TONE_440_480, 1'b1, 1000, NX_NEXT);
        if (idx == 3'd1) return mkSeg(TONE_440, 1'b1, 200, NX_NEXT);
        return mkSeg(TONE_440, 1'b0, 3000, NX_LOOP);
      end
      4'd6: return idx[0] ? mkSeg(TONE_620, 1'b1, 250, NX_LOOP)
                          : mkSeg(TONE_440, 1'b1, 250, NX_NEXT);
      4'd7: return mkSeg(TONE_440, 1'b1, 200, NX_STOP);
      4'd8: return mkSeg(TONE_350_440, !idx[0], 100,
                         (idx == 3'd5) ? NX_STOP : NX_NEXT);
      default: return mkSeg(4'b0000, 1'b0, 1, NX_STOP);
    endcase
  endfunction

endpackage

// File: rtl/cadenceTimer.sv
module cadenceTimer
  import cadence_pkg::*;
#(
  parameter int MS_DIV = 3580
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [DUR_W-1:0] durMs,
  output logic             segDone
);
  localparam int PRE_W = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [DUR_W-1:0] msCnt;
  logic             msTick;

  assign msTick  = (preCnt == PRE_LAST);
  assign segDone = ctl.run && msTick && (msCnt == durMs - DUR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (ctl.restart || !ctl.run) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (msTick) begin
      preCnt <= '0;
      msCnt  <= msCnt + DUR_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/cadenceCtrl.sv
module cadenceCtrl
  import cadence_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             stop,
  input  logic [3:0]       patSel,
  input  logic             segDone,
  output dpCtl_t           ctl,
  output logic [DUR_W-1:0] durMs,
  output logic [3:0]       codeOut,
  output logic             enN,
  output logic             busy
);
  logic             active;
  logic             firstCyc;
  logic [3:0]       patReg;
  logic [IDX_W-1:0] segIdx;
  seg_t             cur;
  logic             takeStart;
  logic             advance;

  assign cur       = segFetch(patReg, segIdx);
  assign takeStart = start && !stop && (patSel < 4'(NUM_PAT));
  assign advance   = active && segDone && (cur.nxt != NX_HOLD);

  assign ctl.restart = stop || takeStart || advance;
  assign ctl.run     = active;
  assign durMs       = cur.durMs;

  assign busy    = active;
  assign codeOut = active ? cur.code : 4'b0000;
  assign enN     = stop || !(active && cur.tone && !firstCyc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      firstCyc <= 1'b0;
      patReg   <= '0;
      segIdx   <= '0;
    end else if (stop) begin
      active   <= 1'b0;
      firstCyc <= 1'b0;
      segIdx   <= '0;
    end else if (takeStart) begin
      active   <= 1'b1;
      firstCyc <= 1'b1;
      patReg   <= patSel;
      segIdx   <= '0;
    end else if (active) begin
      firstCyc <= 1'b0;
      if (advance) begin
        unique case (cur.nxt)
          NX_NEXT: begin segIdx <= segIdx + IDX_W'(1); firstCyc <= 1'b1; end
          NX_LOOP: begin segIdx <= '0;                 firstCyc <= 1'b1; end
          NX_STOP: begin segIdx <= '0; active <= 1'b0; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cadenceSeq.sv
module cadenceSeq
  import cadence_pkg::*;
#(
  parameter int MS_DIV = 3580
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       stop,
  input  logic [3:0] patSel,
  output logic [3:0] codeOut,
  output logic       enN,
  output logic       busy
);
  dpCtl_t           ctl;
  logic [DUR_W-1:0] durMs;
  logic             segDone;

  cadenceCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .patSel(patSel),
    .segDone(segDone), .ctl(ctl), .durMs(durMs),
    .codeOut(codeOut), .enN(enN), .busy(busy)
  );

  cadenceTimer #(.MS_DIV(MS_DIV)) uTimer (
    .clk(clk), .rstN(rstN), .ctl(ctl), .durMs(durMs), .segDone(segDone)
  );
endmodule

// File: rtl/cadenceSeqChk.sv
module cadenceSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       stop,
  input logic [3:0] patSel,
  input logic [3:0] codeOut,
  input logic       enN,
  input logic       busy
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (enN && codeOut == 4'b0000));

  // R3
  latch_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enN) |-> $stable(codeOut));

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enN && !$past(enN)) |-> $stable(codeOut));

  // R11
  stop_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    stop |-> enN);

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> !busy);

  // R13
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && patSel > 4'd8) |=> !busy);
endmodule

bind cadenceSeq cadenceSeqChk chk (.*);

// File: tb/tb_cadenceSeq.sv
module tb_cadenceSeq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic       start, stop;
  logic [3:0] patSel;
  logic [3:0] codeOut;
  logic       enN, busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cadenceSeq #(.MS_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .patSel(patSel),
    .codeOut(codeOut), .enN(enN), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(busy == 1'b0, {req, " busy"}, busy, 0);
    chk(enN == 1'b1, {req, " enN"}, enN, 1);
    chk(codeOut == 4'd0, {req, " code"}, codeOut, 0);
  endtask

  // entered at cycle 0 of the segment (negedge); leaves at the next segment's cycle 0
  task automatic playSeg(input logic [3:0] code, input bit tone, input int ms, input string req);
    for (int c = 0; c < ms * DIV; c++) begin
      chk(busy == 1'b1, {req, " R2 busy"}, busy, 1);
      chk(enN == !(tone && c != 0), {req, " R3 enN"}, enN, !(tone && c != 0));
      if (tone) chk(codeOut == code, {req, " code"}, codeOut, code);
      @(negedge clk);
    end
  endtask

  task automatic startPat(input logic [3:0] p);
    patSel = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic doStop(input string req);
    stop = 1'b1;
    #1;
    chk(enN == 1'b1, {req, " R11 enN during stop"}, enN, 1);
    @(negedge clk);
    stop = 1'b0;
    chkIdle({req, " R11 after stop"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; stop = 1'b0; patSel = 4'd0;
    repeat (3) @(negedge clk);
    chkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after reset");

    // R4 dial steady
    startPat(4'd0);
    playSeg(4'b0000, 1, 60, "R4");
    doStop("R4");

    // R5 reorder and busy
    startPat(4'd1);
    for (int k = 0; k < 2; k++) begin
      playSeg(4'b0110, 1, 250, "R5 reorder on");
      playSeg(4'b0110, 0, 250, "R5 reorder off");
    end
    doStop("R5");
    startPat(4'd2);
    for (int k = 0; k < 2; k++) begin
      playSeg(4'b0110, 1, 500, "R5 busy on");
      playSeg(4'b0110, 0, 500, "R5 busy off");
    end
    doStop("R5");

    // R6 ring
    startPat(4'd3);
    for (int k = 0; k < 2; k++) begin
      playSeg(4'b0011, 1, 2000, "R6 on");
      playSeg(4'b0011, 0, 4000, "R6 off");
    end
    doStop("R6");

    // R7 recall dial
    startPat(4'd4);
    for (int k = 0; k < 3; k++) begin
      playSeg(4'b0000, 1, 100, "R7 burst");
      playSeg(4'b0000, 0, 100, "R7 gap");
    end
    playSeg(4'b0000, 1, 80, "R7 steady");
    doStop("R7");

    // R8 special ring
    startPat(4'd5);
    for (int k = 0; k < 2; k++) begin
      playSeg(4'b0011, 1, 1000, "R8 pair");
      playSeg(4'b0010, 1, 200, "R8 single");
      playSeg(4'b0010, 0, 3000, "R8 silence");
    end
    doStop("R8");

    // R9 intercept
    startPat(4'd6);
    for (int k = 0; k < 3; k++) begin
      playSeg(4'b0010, 1, 250, "R9 low");
      playSeg(4'b1000, 1, 250, "R9 high");
    end
    doStop("R9");

    // R10 call waiting, then idle by itself
    startPat(4'd7);
    playSeg(4'b0010, 1, 200, "R10 waiting");
    for (int k = 0; k < 5; k++) begin
      chkIdle("R10 waiting done");
      @(negedge clk);
    end

    // R10 confirmation
    startPat(4'd8);
    for (int k = 0; k < 3; k++) begin
      playSeg(4'b0000, 1, 100, "R10 confirm on");
      playSeg(4'b0000, 0, 100, "R10 confirm off");
    end
    for (int k = 0; k < 5; k++) begin
      chkIdle("R10 confirm done");
      @(negedge clk);
    end

    // R12 restart mid-segment with another pattern
    startPat(4'd1);
    playSeg(4'b0110, 1, 100, "R12 before");
    startPat(4'd2);
    playSeg(4'b0110, 1, 500, "R12 restarted on");
    playSeg(4'b0110, 0, 500, "R12 restarted off");
    startPat(4'd6);
    playSeg(4'b0010, 1, 30, "R12 same from seg0");
    startPat(4'd6);
    playSeg(4'b0010, 1, 250, "R12 restart full");
    playSeg(4'b1000, 1, 20, "R12 next");
    doStop("R12");

    // R11 stop mid-tone and stop beating start
    startPat(4'd3);
    playSeg(4'b0011, 1, 10, "R11 pre");
    stop = 1'b1; start = 1'b1; patSel = 4'd0;
    #1;
    chk(enN == 1'b1, "R11 enN with stop+start", enN, 1);
    @(negedge clk);
    stop = 1'b0; start = 1'b0;
    chkIdle("R11 stop wins");
    @(negedge clk);
    chkIdle("R11 still idle");

    // R13 invalid selectors ignored
    for (int p = 9; p < 16; p++) begin
      startPat(4'(p));
      chkIdle("R13 invalid sel");
      @(negedge clk);
      chkIdle("R13 invalid sel later");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule